// File: doc/BRIEF.md
# Halt mode power controller

This block sequences the low-power halt of a small microcontroller core. When the core reports that it has executed a halt instruction, the controller picks one of two sleep depths from a status enable bit. The light depth keeps the main oscillator running and gates the CPU and peripheral clocks. The deep depth also stops the oscillator. The block drives the three enables, forces the core's two interrupt mask bits to an interrupts-enabled value on entry, and watches a level-sensitive vector of wake sources together with a reset wake request.

After a wake, the controller holds the core in a stabilization window of 256 or 4096 cycles, chosen by a static configuration input. It then releases all clocks and reports whether the core should fetch the reset vector or service the interrupt that woke it. A watchdog option can refuse the halt: when the watchdog is enabled and halting is not permitted, a halt request yields a watchdog reset pulse and the core keeps running. Domains clocked from an external or auxiliary source are outside this block's gating.

Top module: `halt_pwr_ctrl`

## Requirements
- R1: A halt request in run mode with `lightEn`=1, unless the watchdog trip of R10 applies, makes `mode` read 2'b01 in the next cycle, with `oscEn`=1, `cpuClkEn`=0 and `periClkEn`=0.
- R2: A halt request in run mode with `lightEn`=0, unless the watchdog trip of R10 applies, makes `mode` read 2'b10 in the next cycle, with `oscEn`, `cpuClkEn` and `periClkEn` all 0.
- R3: In the first cycle of either sleep mode `maskForce` is 1 for exactly one cycle, and `maskValue` reads 2'b10.
- R4: A qualified interrupt already pending when the halt is taken causes `mode` to read 2'b11 in the cycle after the sleep mode is first shown.
- R5: While asleep, only `rstWake` or an `irqPend` bit that is set in the current mode's mask (`lightQualMask` in light mode, `deepQualMask` in deep mode) wakes the block; other pending bits leave `mode` unchanged.
- R6: The cycle after a wake source is seen, `mode` reads 2'b11 with `oscEn`=1, `cpuClkEn`=0 and `periClkEn`=0.
- R7: `mode` stays 2'b11 for exactly 256 cycles when `longDelay`=0 and 4096 cycles when `longDelay`=1, then returns to 2'b00 with all three enables at 1.
- R8: `wakeDone` is 1 for exactly the first run cycle after the delay; `wakeByReset` and `wakeIrq` then hold the cause, `wakeIrq` being the pending vector masked by the mode's qualify mask.
- R9: When `rstWake` and a qualified interrupt are seen in the same cycle, the cause is reset: `wakeByReset`=1 and `wakeIrq`=0.
- R10: A halt request with `wdgEnabled`=1 and `wdgHaltOk`=0 produces a one-cycle `wdgRst` pulse in the next cycle, `mode` stays 2'b00 and `maskForce` stays 0; with `wdgHaltOk`=1 the halt proceeds.
- R11: The delay counter restarts on every wake, so each later wake is again the full length of R7.
- R12: After `rstN` is released, `mode` is 2'b00, all three enables are 1, and `maskForce`, `wdgRst` and `wakeDone` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (restarted oscillator clock during the delay) |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| haltReq | input | 1 | One-cycle strobe: the core executed a halt instruction |
| lightEn | input | 1 | Status enable bit selecting the light sleep depth |
| longDelay | input | 1 | Static: 1 selects the 4096-cycle delay, 0 the 256-cycle delay |
| wdgEnabled | input | 1 | Watchdog is running |
| wdgHaltOk | input | 1 | Option bit permitting halt while the watchdog runs |
| irqPend | input | N_IRQ | Level-sensitive pending interrupt vector |
| lightQualMask | input | N_IRQ | Interrupts allowed to wake from light sleep |
| deepQualMask | input | N_IRQ | Interrupts allowed to wake from deep sleep |
| rstWake | input | 1 | Reset wake request |
| oscEn | output | 1 | Main oscillator enable |
| cpuClkEn | output | 1 | CPU clock enable |
| periClkEn | output | 1 | Internally clocked peripheral clock enable |
| maskForce | output | 1 | One-cycle strobe loading `maskValue` into the mask bits |
| maskValue | output | 2 | Mask bit value to force on entry (2'b10) |
| wdgRst | output | 1 | One-cycle watchdog reset request |
| wakeDone | output | 1 | One-cycle strobe: delay over, core resumes |
| wakeByReset | output | 1 | Wake cause: 1 fetch reset vector, 0 service interrupt |
| wakeIrq | output | N_IRQ | Qualified interrupts that caused the wake |
| mode | output | 2 | 00 run, 01 light sleep, 10 deep sleep, 11 wake delay |

## Verification
The reset wake and an interrupt wake can land in the same cycle, and the block must then report a reset cause with an empty interrupt vector. The bench provokes this by raising `rstWake` and a qualified `irqPend` bit on the same edge while in deep sleep, and the scoreboard compares the cause reported at `wakeDone` against the expected item queued by the driver. A second collision, a pending interrupt meeting the halt entry, is provoked by holding a qualified bit before the halt request and judged by the mode sequence 01 then 11 on consecutive cycles.

// File: rtl/halt_pwr_pkg.sv
package halt_pwr_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_LIGHT = 2'b01,
    MODE_DEEP  = 2'b10,
    MODE_WAKE  = 2'b11
  } pwrMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntEn;
    logic capture;
  } dpStrobe_t;

  localparam logic [1:0] MASK_ENABLE_ALL = 2'b10;

endpackage

// File: rtl/halt_pwr_dp.sv
module halt_pwr_dp
  import halt_pwr_pkg::*;
#(
  parameter int N_IRQ     = 8,
  parameter int CNT_W     = 12,
  parameter int SHORT_DLY = 256,
  parameter int LONG_DLY  = 4096
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  pwrMode_e         modeQ,
  input  logic [N_IRQ-1:0] irqPend,
  input  logic [N_IRQ-1:0] lightQualMask,
  input  logic [N_IRQ-1:0] deepQualMask,
  input  logic             rstWake,
  input  logic             longDelay,
  output logic             wakeHit,
  output logic             delayDone,
  output logic             wakeByReset,
  output logic [N_IRQ-1:0] wakeIrq
);

  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_DLY - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_DLY - 1);

  logic [N_IRQ-1:0] qualMask;
  logic [N_IRQ-1:0] qualIrq;
  logic [CNT_W-1:0] lastCnt;
  logic [CNT_W-1:0] dlyCnt;

  always_comb begin
    qualMask = (modeQ == MODE_LIGHT) ? lightQualMask : deepQualMask;
    qualIrq  = irqPend & qualMask;
    wakeHit  = rstWake | (|qualIrq);
    lastCnt  = longDelay ? LONG_LAST : SHORT_LAST;
    delayDone = (dlyCnt == lastCnt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyCnt <= '0;
    end else if (strobe.cntClr) begin
      dlyCnt <= '0;
    end else if (strobe.cntEn) begin
      dlyCnt <= dlyCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeByReset <= 1'b0;
      wakeIrq     <= '0;
    end else if (strobe.capture) begin
      wakeByReset <= rstWake;
      wakeIrq     <= rstWake ? '0 : qualIrq;
    end
  end

  // R7: the count never passes the selected last value
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntEn |-> (dlyCnt <= lastCnt));

  // R9: reset wins over a simultaneous interrupt
  a_r9_reset_first: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && rstWake) |=> (wakeByReset && (wakeIrq == '0)));

  // R11: a new wake starts counting from zero
  a_r11_cnt_restart: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClr |=> (dlyCnt == '0));

endmodule

// File: rtl/halt_pwr_fsm.sv
module halt_pwr_fsm
  import halt_pwr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      haltReq,
  input  logic      lightEn,
  input  logic      wdgEnabled,
  input  logic      wdgHaltOk,
  input  logic      wakeHit,
  input  logic      delayDone,
  output pwrMode_e  modeQ,
  output dpStrobe_t strobe,
  output logic      maskForce,
  output logic      wdgRst,
  output logic      wakeDone
);

  pwrMode_e modeD;
  logic     enterHalt;
  logic     wdgTrip;
  logic     finish;

  always_comb begin
    modeD     = modeQ;
    strobe    = '0;
    enterHalt = 1'b0;
    wdgTrip   = 1'b0;
    finish    = 1'b0;
    case (modeQ)
      MODE_RUN: begin
        if (haltReq) begin
          if (wdgEnabled && !wdgHaltOk) begin
            wdgTrip = 1'b1;
          end else begin
            modeD     = lightEn ? MODE_LIGHT : MODE_DEEP;
            enterHalt = 1'b1;
          end
        end
      end
      MODE_LIGHT, MODE_DEEP: begin
        if (wakeHit) begin
          modeD          = MODE_WAKE;
          strobe.cntClr  = 1'b1;
          strobe.capture = 1'b1;
        end
      end
      MODE_WAKE: begin
        strobe.cntEn = 1'b1;
        if (delayDone) begin
          modeD  = MODE_RUN;
          finish = 1'b1;
        end
      end
      default: modeD = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ     <= MODE_RUN;
      maskForce <= 1'b0;
      wdgRst    <= 1'b0;
      wakeDone  <= 1'b0;
    end else begin
      modeQ     <= modeD;
      maskForce <= enterHalt;
      wdgRst    <= wdgTrip;
      wakeDone  <= finish;
    end
  end

  // R3: every entry into sleep is accompanied by the mask strobe
  a_r3_mask_on_entry: assert property (@(posedge clk) disable iff (!rstN)
    ((modeQ == MODE_LIGHT || modeQ == MODE_DEEP) && $past(modeQ) == MODE_RUN)
      |-> maskForce);

  // R10: a watchdog trip never comes with a sleep entry
  a_r10_wdg_stays_run: assert property (@(posedge clk) disable iff (!rstN)
    wdgRst |-> (modeQ == MODE_RUN && !maskForce));

  // R8: resume strobe only right after the delay window
  a_r8_done_after_delay: assert property (@(posedge clk) disable iff (!rstN)
    wakeDone |-> (modeQ == MODE_RUN && $past(modeQ) == MODE_WAKE));

  // R5: a sleep mode is left only towards the delay window
  a_r5_sleep_exit: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeQ) == MODE_LIGHT && modeQ != MODE_LIGHT) |-> (modeQ == MODE_WAKE));

endmodule

// File: rtl/halt_pwr_ctrl.sv
module halt_pwr_ctrl
  import halt_pwr_pkg::*;
#(
  parameter int N_IRQ     = 8,
  parameter int CNT_W     = 12,
  parameter int SHORT_DLY = 256,
  parameter int LONG_DLY  = 4096
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             haltReq,
  input  logic             lightEn,
  input  logic             longDelay,
  input  logic             wdgEnabled,
  input  logic             wdgHaltOk,
  input  logic [N_IRQ-1:0] irqPend,
  input  logic [N_IRQ-1:0] lightQualMask,
  input  logic [N_IRQ-1:0] deepQualMask,
  input  logic             rstWake,
  output logic             oscEn,
  output logic             cpuClkEn,
  output logic             periClkEn,
  output logic             maskForce,
  output logic [1:0]       maskValue,
  output logic             wdgRst,
  output logic             wakeDone,
  output logic             wakeByReset,
  output logic [N_IRQ-1:0] wakeIrq,
  output logic [1:0]       mode
);

  pwrMode_e  modeQ;
  dpStrobe_t strobe;
  logic      wakeHit;
  logic      delayDone;

  halt_pwr_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .haltReq    (haltReq),
    .lightEn    (lightEn),
    .wdgEnabled (wdgEnabled),
    .wdgHaltOk  (wdgHaltOk),
    .wakeHit    (wakeHit),
    .delayDone  (delayDone),
    .modeQ      (modeQ),
    .strobe     (strobe),
    .maskForce  (maskForce),
    .wdgRst     (wdgRst),
    .wakeDone   (wakeDone)
  );

  halt_pwr_dp #(
    .N_IRQ     (N_IRQ),
    .CNT_W     (CNT_W),
    .SHORT_DLY (SHORT_DLY),
    .LONG_DLY  (LONG_DLY)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .modeQ         (modeQ),
    .irqPend       (irqPend),
    .lightQualMask (lightQualMask),
    .deepQualMask  (deepQualMask),
    .rstWake       (rstWake),
    .longDelay     (longDelay),
    .wakeHit       (wakeHit),
    .delayDone     (delayDone),
    .wakeByReset   (wakeByReset),
    .wakeIrq       (wakeIrq)
  );

  assign oscEn     = (modeQ != MODE_DEEP);
  assign cpuClkEn  = (modeQ == MODE_RUN);
  assign periClkEn = (modeQ == MODE_RUN);
  assign maskValue = MASK_ENABLE_ALL;
  assign mode      = modeQ;

endmodule

// File: tb/halt_pwr_ctrl_tb_top.sv
module halt_pwr_ctrl_tb_top;

  localparam int NI = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          haltReq = 1'b0, lightEn = 1'b0, longDelay = 1'b0;
  logic          wdgEnabled = 1'b0, wdgHaltOk = 1'b0, rstWake = 1'b0;
  logic [NI-1:0] irqPend = '0, lightQualMask = 8'h0F, deepQualMask = 8'h01;
  logic          oscEn, cpuClkEn, periClkEn, maskForce, wdgRst, wakeDone, wakeByReset;
  logic [1:0]    maskValue, mode;
  logic [NI-1:0] wakeIrq;

  int checks = 0;
  int failures = 0;
  int wakeLen = 0;

  typedef struct {
    bit            byRst;
    logic [NI-1:0] irq;
    int            dly;
    string         tag;
  } expItem_t;
  expItem_t expQ[$];

  always #2 clk = ~clk;

  halt_pwr_ctrl dut_i (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .lightEn(lightEn),
    .longDelay(longDelay), .wdgEnabled(wdgEnabled), .wdgHaltOk(wdgHaltOk),
    .irqPend(irqPend), .lightQualMask(lightQualMask), .deepQualMask(deepQualMask),
    .rstWake(rstWake), .oscEn(oscEn), .cpuClkEn(cpuClkEn), .periClkEn(periClkEn),
    .maskForce(maskForce), .maskValue(maskValue), .wdgRst(wdgRst),
    .wakeDone(wakeDone), .wakeByReset(wakeByReset), .wakeIrq(wakeIrq), .mode(mode)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chkMode(input string req, input int m, input int o, input int c, input int p);
    chk(mode == m[1:0], req, "mode", mode, m);
    chk(oscEn == o[0], req, "oscEn", oscEn, o);
    chk(cpuClkEn == c[0], req, "cpuClkEn", cpuClkEn, c);
    chk(periClkEn == p[0], req, "periClkEn", periClkEn, p);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doHalt();
    haltReq = 1'b1;
    tick(1);
    haltReq = 1'b0;
  endtask

  task automatic pushExp(input bit r, input logic [NI-1:0] v, input int d, input string t);
    expItem_t it;
    it.byRst = r; it.irq = v; it.dly = d; it.tag = t;
    expQ.push_back(it);
  endtask

  task automatic waitDone(input string req);
    bit seen = 0;
    for (int i = 0; i < 6000 && !seen; i++) begin
      @(negedge clk);
      if (wakeDone) seen = 1;
    end
    chk(seen, req, "wakeDone seen", seen, 1);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (mode == 2'b11) wakeLen++;
      if (wakeDone) begin
        if (expQ.size() == 0) begin
          chk(0, "R8", "unexpected wakeDone", 1, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          chk(wakeLen == e.dly, e.tag, "wake delay length", wakeLen, e.dly);
          chk(wakeByReset == e.byRst, "R8", "wakeByReset", wakeByReset, e.byRst);
          chk(wakeIrq == e.irq, "R8", "wakeIrq", wakeIrq, e.irq);
        end
        wakeLen = 0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog timeout actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R12 reset state
    chkMode("R12", 0, 1, 1, 1);
    chk(!maskForce && !wdgRst && !wakeDone, "R12", "strobes idle", maskForce, 0);

    // light sleep, short delay
    lightEn = 1'b1; longDelay = 1'b0;
    doHalt();
    chkMode("R1", 1, 1, 0, 0);
    chk(maskForce == 1'b1, "R3", "maskForce at entry", maskForce, 1);
    chk(maskValue == 2'b10, "R3", "maskValue", maskValue, 2);
    tick(1);
    chk(maskForce == 1'b0, "R3", "maskForce one cycle", maskForce, 0);
    irqPend = 8'h10;                     // not in lightQualMask
    tick(3);
    chk(mode == 2'b01, "R5", "unqualified irq ignored (light)", mode, 1);
    pushExp(0, 8'h04, 256, "R7");
    irqPend = 8'h14;
    tick(1);
    chkMode("R6", 3, 1, 0, 0);
    irqPend = '0;
    waitDone("R7");
    chkMode("R7", 0, 1, 1, 1);
    tick(1);
    chk(wakeDone == 1'b0, "R8", "wakeDone one cycle", wakeDone, 0);

    // deep sleep, long delay, reset and irq together
    lightEn = 1'b0; longDelay = 1'b1;
    doHalt();
    chkMode("R2", 2, 0, 0, 0);
    chk(maskForce == 1'b1, "R3", "maskForce deep entry", maskForce, 1);
    irqPend = 8'h02;                     // in light mask but not deep mask
    tick(3);
    chk(mode == 2'b10, "R5", "unqualified irq ignored (deep)", mode, 2);
    pushExp(1, 8'h00, 4096, "R7");
    irqPend = 8'h01; rstWake = 1'b1;     // R9 collision
    tick(1);
    chkMode("R6", 3, 1, 0, 0);
    irqPend = '0; rstWake = 1'b0;
    waitDone("R9");

    // pending interrupt at entry
    lightEn = 1'b1; longDelay = 1'b0;
    irqPend = 8'h08;
    pushExp(0, 8'h08, 256, "R7");
    doHalt();
    chk(mode == 2'b01, "R4", "light first", mode, 1);
    tick(1);
    chk(mode == 2'b11, "R4", "immediate wake", mode, 3);
    irqPend = '0;
    waitDone("R4");

    // watchdog refuses halt
    wdgEnabled = 1'b1; wdgHaltOk = 1'b0;
    doHalt();
    chk(wdgRst == 1'b1, "R10", "wdgRst pulse", wdgRst, 1);
    chk(mode == 2'b00, "R10", "stay run", mode, 0);
    chk(maskForce == 1'b0, "R10", "no mask strobe", maskForce, 0);
    tick(1);
    chk(wdgRst == 1'b0, "R10", "wdgRst one cycle", wdgRst, 0);
    wdgHaltOk = 1'b1;
    doHalt();
    chk(mode == 2'b01, "R10", "halt allowed", mode, 1);
    chk(wdgRst == 1'b0, "R10", "no trip when allowed", wdgRst, 0);
    pushExp(1, 8'h00, 256, "R11");
    rstWake = 1'b1;
    tick(1);
    rstWake = 1'b0;
    waitDone("R11");

    // second long wake: counter restarted
    lightEn = 1'b0; longDelay = 1'b1;
    doHalt();
    pushExp(0, 8'h01, 4096, "R11");
    irqPend = 8'h01;
    tick(1);
    irqPend = '0;
    waitDone("R11");
    chkMode("R11", 0, 1, 1, 1);

    tick(2);
    chk(expQ.size() == 0, "R8", "all wakes reported", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule